// File: doc/BRIEF.md
# Serial Link Host Adaptor

This block connects a byte-wide host bus to a point-to-point serial link that works by handshake. The host reaches four registers through a two-bit address. One register holds the received byte and one takes the byte to send. Two status registers each hold a flag and an interrupt enable. The link side has a one-bit transmit line and a one-bit receive line. Both move one bit per clock cycle. Each line carries two kinds of packet: data packets and acknowledge packets.

The sender may not push a new byte until the far end has acknowledged the previous one. The host side gets the acknowledge that paces it on the receive line. The acknowledge that paces the far end is sent when the host reads the received byte. The transmit-ready flag therefore follows both the local transmitter and the far end's acknowledge. The data-present flag follows arriving packets and host reads.

Top module: `slink_host_if`

## Requirements
- R1: Register map on `host_addr`:
  - 0 reads the received byte.
  - 1 is input status: bit 0 is data-present, bit 1 is the input interrupt enable.
  - 2 takes the byte to send.
  - 3 is output status: bit 0 is transmit-ready, bit 1 is the output interrupt enable.
  - All other status bits read 0. Writes change only bit 1 of a status register; bit 0 ignores writes.
- R2: `out_irq` is high exactly when transmit-ready and the output interrupt enable are both set.
- R3: A write to address 2 while transmit-ready is set clears transmit-ready and `out_irq`. It then sends the byte on `ser_tx` as 1, 1, d0..d7 (LSB first), 0, one bit per clock. `ser_tx` idles low.
- R4: After such a write, transmit-ready stays low until both of these have happened, in either order:
  - the data packet has been fully sent;
  - an acknowledge packet (1 then 0) has been received on `ser_rx`.
- R5: A write to address 2 while transmit-ready is clear is ignored. No byte is sent and the queued byte is unchanged.
- R6: A data packet received on `ser_rx` (1, 1, d0..d7 LSB first, stop bit) sets data-present and captures the byte for address 0.
- R7: `in_irq` is high exactly when data-present and the input interrupt enable are both set.
- R8: A read of address 0 while data-present is set does three things:
  - clears data-present;
  - drops `in_irq`;
  - sends one acknowledge packet (1, 0) on `ser_tx`.
- R9: A read of address 0 while data-present is clear sends no acknowledge. Accessing input status does not clear data-present or `in_irq`.
- R10: A packet in progress on `ser_tx` is never interrupted. An acknowledge requested during a data packet follows that data packet.
- R11: After reset:
  - transmit-ready is 1;
  - data-present and both enables are 0;
  - both interrupts are low;
  - `ser_tx` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| in_irq | output | 1 | Received-byte interrupt |
| out_irq | output | 1 | Transmit-ready interrupt |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |

## Verification
The hardest case to reach is an acknowledge that arrives on `ser_rx` while the data packet is still being shifted out. A correct far end never does this, and an early acknowledge must not raise transmit-ready. The bench drives an acknowledge packet right after the host write, checks that transmit-ready is still low mid-packet, and checks that it rises only once the packet has ended. A second directed case requests an acknowledge during an outgoing data packet. A bench-side line decoder then checks that the data packet ends whole and the acknowledge follows it.

// File: rtl/slink_pkg.sv
package slink_pkg;

    // Host register addresses
    typedef enum logic [1:0] {
        REG_RXDATA = 2'd0,
        REG_RXSTAT = 2'd1,
        REG_TXDATA = 2'd2,
        REG_TXSTAT = 2'd3
    } reg_addr_e;

    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_IEN_BIT  = 1;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HDR,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/slink_tx.sv
module slink_tx
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_data,
    input  logic [DATA_W-1:0] data,
    input  logic              req_ack,
    output logic              take_data,
    output logic              take_ack,
    output logic              data_done,
    output logic              line
);
    localparam int PKT_W = DATA_W + 3;
    localparam int CNT_W = $clog2(PKT_W + 1);

    typedef struct packed {
        tx_state_e        st;
        logic [PKT_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic             is_data;
        logic             line;
    } tx_s;

    tx_s tx_q, tx_d;

    always_comb begin
        tx_d      = tx_q;
        tx_d.line = 1'b0;
        take_data = 1'b0;
        take_ack  = 1'b0;
        data_done = 1'b0;
        case (tx_q.st)
            TX_IDLE: begin
                // acknowledge wins a tie at idle; nothing preempts a packet
                if (req_ack) begin
                    take_ack     = 1'b1;
                    tx_d.st      = TX_SHIFT;
                    tx_d.sh      = PKT_W'(1);
                    tx_d.cnt     = CNT_W'(2);
                    tx_d.is_data = 1'b0;
                end else if (req_data) begin
                    take_data    = 1'b1;
                    tx_d.st      = TX_SHIFT;
                    tx_d.sh      = {1'b0, data, 2'b11};
                    tx_d.cnt     = CNT_W'(PKT_W);
                    tx_d.is_data = 1'b1;
                end
            end
            TX_SHIFT: begin
                tx_d.line = tx_q.sh[0];
                tx_d.sh   = tx_q.sh >> 1;
                tx_d.cnt  = tx_q.cnt - CNT_W'(1);
                if (tx_q.cnt == CNT_W'(1)) begin
                    tx_d.st   = TX_IDLE;
                    data_done = tx_q.is_data;
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '{st: TX_IDLE, sh: '0, cnt: '0, is_data: 1'b0, line: 1'b0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign line = tx_q.line;

endmodule

// File: rtl/slink_rx.sv
module slink_rx
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_out,
    output logic              ack_vld
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              byte_vld;
        logic              ack_vld;
    } rx_s;

    rx_s rx_q, rx_d;

    always_comb begin
        rx_d          = rx_q;
        rx_d.byte_vld = 1'b0;
        rx_d.ack_vld  = 1'b0;
        case (rx_q.st)
            RX_IDLE: if (line) rx_d.st = RX_HDR;
            RX_HDR: begin
                if (line) begin
                    rx_d.st  = RX_DATA;
                    rx_d.cnt = '0;
                end else begin
                    rx_d.st      = RX_IDLE;
                    rx_d.ack_vld = 1'b1;
                end
            end
            RX_DATA: begin
                rx_d.sh  = {line, rx_q.sh[DATA_W-1:1]};
                rx_d.cnt = rx_q.cnt + CNT_W'(1);
                if (rx_q.cnt == CNT_W'(DATA_W - 1)) rx_d.st = RX_STOP;
            end
            RX_STOP: begin
                rx_d.st       = RX_IDLE;
                rx_d.byte_vld = 1'b1;
            end
            default: rx_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '{st: RX_IDLE, cnt: '0, sh: '0, byte_vld: 1'b0, ack_vld: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld = rx_q.byte_vld;
    assign byte_out = rx_q.sh;
    assign ack_vld  = rx_q.ack_vld;

endmodule

// File: rtl/slink_host_if.sv
module slink_host_if
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              in_irq,
    output logic              out_irq,
    input  logic              ser_rx,
    output logic              ser_tx
);
    localparam int PAD_W = DATA_W - 2;

    typedef struct packed {
        logic              dp;
        logic [DATA_W-1:0] rx_buf;
        logic              in_ien;
        logic              out_ien;
        logic [DATA_W-1:0] obuf;
        logic              obuf_full;
        logic              inflight;
        logic              ack_got;
        logic              ack_pend;
    } host_s;

    host_s hq, hd;

    logic              rx_valid, rx_ack;
    logic [DATA_W-1:0] rx_byte;
    logic              take_data, take_ack, data_done;
    logic              rd_strobe, wr_strobe, out_ready;
    reg_addr_e         addr;

    slink_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (ser_rx),
        .byte_vld (rx_valid),
        .byte_out (rx_byte),
        .ack_vld  (rx_ack)
    );

    slink_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_data  (hq.obuf_full),
        .data      (hq.obuf),
        .req_ack   (hq.ack_pend),
        .take_data (take_data),
        .take_ack  (take_ack),
        .data_done (data_done),
        .line      (ser_tx)
    );

    assign addr      = reg_addr_e'(host_addr);
    assign rd_strobe = host_sel & ~host_wr;
    assign wr_strobe = host_sel & host_wr;
    assign out_ready = ~hq.inflight & hq.ack_got;

    always_comb begin
        hd = hq;
        if (take_data) hd.obuf_full = 1'b0;
        if (take_ack)  hd.ack_pend  = 1'b0;
        if (data_done) hd.inflight  = 1'b0;
        if (rx_ack)    hd.ack_got   = 1'b1;

        if (rd_strobe && addr == REG_RXDATA && hq.dp) begin
            hd.dp       = 1'b0;
            hd.ack_pend = 1'b1;
        end
        if (rx_valid) begin
            hd.dp     = 1'b1;
            hd.rx_buf = rx_byte;
        end

        if (wr_strobe) begin
            case (addr)
                REG_RXSTAT: hd.in_ien  = host_wdata[STAT_IEN_BIT];
                REG_TXSTAT: hd.out_ien = host_wdata[STAT_IEN_BIT];
                REG_TXDATA: begin
                    if (out_ready) begin
                        hd.obuf      = host_wdata;
                        hd.obuf_full = 1'b1;
                        hd.inflight  = 1'b1;
                        hd.ack_got   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hq <= '{dp: 1'b0, rx_buf: '0, in_ien: 1'b0, out_ien: 1'b0,
                    obuf: '0, obuf_full: 1'b0, inflight: 1'b0,
                    ack_got: 1'b1, ack_pend: 1'b0};
        end else begin
            hq <= hd;
        end
    end

    always_comb begin
        case (addr)
            REG_RXDATA: host_rdata = hq.rx_buf;
            REG_RXSTAT: host_rdata = {{PAD_W{1'b0}}, hq.in_ien, hq.dp};
            REG_TXSTAT: host_rdata = {{PAD_W{1'b0}}, hq.out_ien, out_ready};
            default:    host_rdata = '0;
        endcase
    end

    assign in_irq  = hq.dp & hq.in_ien;
    assign out_irq = out_ready & hq.out_ien;

endmodule

// File: rtl/slink_host_if_chk.sv
module slink_host_if_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_wr,
    input logic [1:0]        host_addr,
    input logic              dp,
    input logic              out_ready,
    input logic              in_irq,
    input logic              out_irq,
    input logic              rx_valid,
    input logic              rx_ack,
    input logic              data_done,
    input logic              ack_pend,
    input logic [DATA_W-1:0] obuf
);
    logic wr_tx, rd_rx, rd_stat;
    assign wr_tx   = host_sel && host_wr && host_addr == 2'd2;
    assign rd_rx   = host_sel && !host_wr && host_addr == 2'd0;
    assign rd_stat = host_sel && host_addr == 2'd1;

    assert_write_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx && out_ready |=> !out_ready && !out_irq);

    assert_ready_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ready) |-> $past(rx_ack) || $past(data_done));

    assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx && !out_ready |=> $stable(obuf) && !out_ready);

    assert_rx_sets_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> dp);

    assert_read_acks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx && dp && !rx_valid |=> !dp && !in_irq && ack_pend);

    assert_status_keeps_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat && dp |=> dp);

endmodule

bind slink_host_if slink_host_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .dp        (hq.dp),
    .out_ready (out_ready),
    .in_irq    (in_irq),
    .out_irq   (out_irq),
    .rx_valid  (rx_valid),
    .rx_ack    (rx_ack),
    .data_done (data_done),
    .ack_pend  (hq.ack_pend),
    .obuf      (hq.obuf)
);

// File: tb/slink_host_if_bench.sv
`timescale 1ns/1ps
module slink_host_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       in_irq, out_irq;
    logic       ser_rx = 1'b0;
    logic       ser_tx;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slink_host_if u_slink_host_if (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .in_irq(in_irq), .out_irq(out_irq), .ser_rx(ser_rx), .ser_tx(ser_tx)
    );

    // far-end decoder of ser_tx
    int          mon_st = 0, mon_cnt = 0, mon_acks = 0, mon_bytes = 0;
    logic [7:0]  mon_sh = 8'h00, mon_last = 8'h00;
    logic [31:0] mon_order = '0;   // 1 = data packet, 0 = acknowledge
    always @(negedge clk) begin
        if (!rst_n) mon_st = 0;
        else case (mon_st)
            0: if (ser_tx) mon_st = 1;
            1: if (ser_tx) begin mon_st = 2; mon_cnt = 0; end
               else begin mon_acks++; mon_order = {mon_order[30:0], 1'b0}; mon_st = 0; end
            2: begin mon_sh = {ser_tx, mon_sh[7:1]}; mon_cnt++; if (mon_cnt == 8) mon_st = 3; end
            default: begin mon_bytes++; mon_last = mon_sh;
                           mon_order = {mon_order[30:0], 1'b1}; mon_st = 0; end
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); host_sel = 1; host_wr = 1; host_addr = a; host_wdata = v;
        @(negedge clk); host_sel = 0; host_wr = 0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); host_sel = 1; host_wr = 0; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk); host_sel = 0;
    endtask

    task automatic far_send_byte(input logic [7:0] b);
        logic [10:0] pk;
        pk = {1'b0, b, 2'b11};
        for (int i = 0; i < 11; i++) begin @(negedge clk); ser_rx = pk[i]; end
        @(negedge clk); ser_rx = 0;
    endtask

    task automatic far_send_ack();
        @(negedge clk); ser_rx = 1;
        @(negedge clk); ser_rx = 0;
        @(negedge clk);
    endtask

    // {host-to-far byte, far-to-host byte}
    localparam logic [15:0] VECS [0:5] = '{
        16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int acks0, bytes0;
        idle(3);
        rst_n = 1;
        idle(2);

        // R11 reset state, R2 gating with enable clear
        host_read(2'd3, v); check(v == 8'h01, "R11 txstat", v, 8'h01);
        host_read(2'd1, v); check(v == 8'h00, "R11 rxstat", v, 8'h00);
        check(in_irq == 0, "R11 in_irq", in_irq, 0);
        check(out_irq == 0, "R2 out_irq gated by enable", out_irq, 0);
        check(ser_tx == 0, "R11 ser_tx idle", ser_tx, 0);

        // R1 status bit0 not writable, other bits zero
        host_write(2'd1, 8'hFF);
        host_read(2'd1, v); check(v == 8'h02, "R1 rxstat write", v, 8'h02);
        check(in_irq == 0, "R7 no irq without present", in_irq, 0);
        host_write(2'd3, 8'hFE);
        host_read(2'd3, v); check(v == 8'h03, "R1 txstat write", v, 8'h03);
        check(out_irq == 1, "R2 out_irq", out_irq, 1);

        // R9 read with nothing present: no acknowledge
        acks0 = mon_acks;
        host_read(2'd0, v); idle(8);
        check(mon_acks == acks0, "R9 no ack when empty", mon_acks, acks0);

        foreach (VECS[k]) begin
            logic [7:0] tb_out, tb_in;
            tb_out = VECS[k][15:8]; tb_in = VECS[k][7:0];
            // receive path: R6, R7, R8
            far_send_byte(tb_in); idle(3);
            host_read(2'd1, v); check(v == 8'h03, "R6 present", v, 8'h03);
            check(in_irq == 1, "R7 in_irq", in_irq, 1);
            acks0 = mon_acks;
            host_read(2'd0, v); check(v == tb_in, "R6 byte", v, tb_in);
            check(in_irq == 0, "R8 in_irq cleared", in_irq, 0);
            idle(6);
            check(mon_acks == acks0 + 1, "R8 ack sent", mon_acks, acks0 + 1);
            // transmit path: R3, R4
            bytes0 = mon_bytes;
            host_write(2'd2, tb_out);
            check(out_irq == 0, "R3 out_irq cleared", out_irq, 0);
            idle(16);
            check(mon_bytes == bytes0 + 1 && mon_last == tb_out, "R3 byte on line", mon_last, tb_out);
            host_read(2'd3, v); check(v == 8'h02, "R4 ready waits for ack", v, 8'h02);
            far_send_ack(); idle(2);
            host_read(2'd3, v); check(v == 8'h03, "R4 ready after ack", v, 8'h03);
            check(out_irq == 1, "R2 out_irq back", out_irq, 1);
        end

        // R5 write while busy is ignored
        bytes0 = mon_bytes;
        host_write(2'd2, 8'h96);
        host_write(2'd2, 8'h69);
        idle(30);
        check(mon_bytes == bytes0 + 1, "R5 one packet", mon_bytes, bytes0 + 1);
        check(mon_last == 8'h96, "R5 first byte kept", mon_last, 8'h96);
        far_send_ack(); idle(2);

        // R4 early acknowledge during the data packet
        host_write(2'd2, 8'h4D);
        far_send_ack();
        host_read(2'd3, v); check(v == 8'h02, "R4 early ack not ready", v, 8'h02);
        idle(14);
        host_read(2'd3, v); check(v == 8'h03, "R4 ready after packet", v, 8'h03);

        // R9 status access keeps present; R10 ack follows data packet
        far_send_byte(8'hE7); idle(3);
        host_read(2'd1, v); host_write(2'd1, 8'h02);
        check(in_irq == 1, "R9 status keeps irq", in_irq, 1);
        host_write(2'd2, 8'h2B);
        host_read(2'd0, v); check(v == 8'hE7, "R10 byte", v, 8'hE7);
        idle(20);
        check(mon_order[1:0] == 2'b10, "R10 data then ack", mon_order[1:0], 2'b10);
        check(mon_last == 8'h2B, "R10 data intact", mon_last, 8'h2B);
        check(ser_tx == 0, "R3 line idles low", ser_tx, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule